// File: doc/BRIEF.md
# Nibble-Loaded Double-Buffered Converter Code Register

This block is the bus-side front end of a 12-bit converter attached to a 4-bit processor data bus. A host writes the code one nibble at a time into three holding registers, choosing the nibble with a 2-bit address. A fourth address value moves all three nibbles into the 12-bit output code register in a single clock, so the converter never sees a half-written code.

The bus follows static-RAM write timing with active-low chip select and write strobe. All bus inputs cross into the system clock domain through a two-stage synchronizer. The selected operation is committed once, when the synchronized write strobe rises while chip select is low. An active-low clear input empties the output register at once, without waiting for a clock, and leaves the holding registers alone. A one-cycle `update` flag tells downstream logic that the code has just changed.

Top module: `nibble_dac_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `code` becomes 0 and all three holding registers become 0, so a transfer issued right after reset yields code 0.
- R2: A committed write with `addr` = 0 stores `din` in the low holding nibble, `addr` = 1 in the middle nibble, and `addr` = 2 in the high nibble.
- R3: A committed write with `addr` = 3 loads `code` with high nibble in bits 11:8, middle in bits 7:4 and low in bits 3:0, all in the same clock edge.
- R4: Writes to holding registers (`addr` 0 to 2) leave `code` unchanged until a transfer is committed.
- R5: When `cs_n` is high at the rising edge of `wr_n`, no holding register and no bit of `code` changes.
- R6: An operation is committed once per write strobe. With bus inputs stable, `code` takes its new value at the third rising clock edge after `wr_n` rises and is unchanged after the second.
- R7: `clr_n` low forces `code` to 0 without a clock edge and holds it there, overriding a transfer committed at the same time.
- R8: Clear leaves the holding registers unchanged, so a later transfer restores the previously written nibbles.
- R9: `update` is high for exactly one clock period after `code` changes value, by transfer or by clear. A transfer that leaves the value unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear of the output code |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; operation commits on its rising edge |
| addr | input | 2 | 0 low nibble, 1 middle nibble, 2 high nibble, 3 transfer |
| din | input | 4 | Nibble data bus |
| code | output | 12 | Output converter code |
| update | output | 1 | One-cycle flag after `code` changes |

## Verification
On every cycle the assertions check that a holding nibble changes only on a commit that selects it, that the code moves only on a transfer or clear, that a transfer carries the assembled holding word, that clear keeps the code at zero, and that commits never come on back-to-back cycles. The bench's scenarios show what those properties cannot: the exact commit latency after the strobe rises, the nibble ordering within the code, the ignored write with chip select high, clear colliding with a transfer, and the holding contents surviving a clear.

// File: rtl/nibble_dac_pkg.sv
package nibble_dac_pkg;
  localparam int NIB_W   = 4;
  localparam int N_NIB   = 3;
  localparam int CODE_W  = NIB_W * N_NIB;
  localparam int ADDR_W  = 2;
  localparam int BUS_W   = 2 + ADDR_W + NIB_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_XFER = 2'd3
  } sel_t;

  // Nibble i occupies bits [i*NIB_W +: NIB_W]; index 0 is the low nibble.
  function automatic logic [CODE_W-1:0] place_nibble(input logic [NIB_W-1:0] nib, input int idx);
    logic [CODE_W-1:0] w;
    w = '0;
    w[idx*NIB_W +: NIB_W] = nib;
    return w;
  endfunction
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      stage[s] <= IDLE;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[(s > 0) ? s-1 : 0];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/write_strobe.sv
module write_strobe
  import nibble_dac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s_n,
  input  logic             wr_s_n,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [NIB_W-1:0]  din_s,
  output logic             commit,
  output sel_t             sel,
  output logic [NIB_W-1:0] nib
);
  logic wr_prev_n;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_prev_n <= 1'b1;
    else        wr_prev_n <= wr_s_n;
  end

  assign commit = wr_s_n && !wr_prev_n && !cs_s_n;
  assign sel    = sel_t'(addr_s);
  assign nib    = din_s;

  a_r6_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/code_bank.sv
module code_bank
  import nibble_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              commit,
  input  sel_t              sel,
  input  logic [NIB_W-1:0]  nib,
  output logic [CODE_W-1:0] code,
  output logic              update
);
  logic [NIB_W-1:0]  hold [N_NIB];
  logic [CODE_W-1:0] word;
  logic [CODE_W-1:0] code_d1;
  logic              xfer;

  assign xfer = commit && (sel == SEL_XFER);

  for (genvar g = 0; g < N_NIB; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                                  hold[g] <= '0;
      else if (commit && (sel == sel_t'(2'(g))))   hold[g] <= nib;
    end

    a_r5_hold_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && (sel == sel_t'(2'(g)))) |=> $stable(hold[g]));
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < N_NIB; i++) word = word | place_nibble(hold[i], i);
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      code <= '0;
    else if (!rst_n) code <= '0;
    else if (xfer)   code <= word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_d1 <= '0;
    else        code_d1 <= code;
  end

  assign update = (code != code_d1);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (code == '0) && !update);
  a_r3_xfer_word: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && clr_n) |=> (code == $past(word)) || (code == '0));
  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> (code == $past(code)) || (code == '0));
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code == '0));
endmodule

// File: rtl/nibble_dac_reg.sv
module nibble_dac_reg
  import nibble_dac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_n,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic [1:0]  addr,
  input  logic [3:0]  din,
  output logic [11:0] code,
  output logic        update
);
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, {(ADDR_W+NIB_W){1'b0}}};

  logic [BUS_W-1:0]  bus_s;
  logic              commit;
  sel_t              sel;
  logic [NIB_W-1:0]  nib;

  bus_sync #(.W(BUS_W), .STAGES(2), .IDLE(BUS_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, wr_n, addr, din}),
    .q     (bus_s)
  );

  write_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_s_n (bus_s[BUS_W-1]),
    .wr_s_n (bus_s[BUS_W-2]),
    .addr_s (bus_s[NIB_W +: ADDR_W]),
    .din_s  (bus_s[NIB_W-1:0]),
    .commit (commit),
    .sel    (sel),
    .nib    (nib)
  );

  code_bank u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .commit (commit),
    .sel    (sel),
    .nib    (nib),
    .code   (code),
    .update (update)
  );
endmodule

// File: tb/nibble_dac_reg_tb.sv
module nibble_dac_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [3:0]  din = 4'd0;
  logic [11:0] code;
  logic        update;

  int n_tests = 0;
  int n_fail  = 0;
  logic [3:0]  m_lo = 0, m_mid = 0, m_hi = 0;
  logic [11:0] m_code = 0;

  always #4 clk = ~clk;

  nibble_dac_reg u_dut (.clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n),
    .wr_n(wr_n), .addr(addr), .din(din), .code(code), .update(update));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model_word();
    return {m_hi, m_mid, m_lo};
  endfunction

  // One bus write; checks latency, result and the update pulse.
  task automatic bus_op(input logic [1:0] a, input logic [3:0] d, input logic sel_n, input string req);
    logic [11:0] exp;
    exp = m_code;
    if (!sel_n) begin
      case (a)
        2'd0: m_lo  = d;
        2'd1: m_mid = d;
        2'd2: m_hi  = d;
        default: exp = model_word();
      endcase
    end
    @(negedge clk); addr = a; din = d; cs_n = sel_n;
    @(negedge clk); wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(posedge clk);
    #2 chk(code == m_code, {req, " R6 before third edge"}, code, m_code);
    @(posedge clk); #2;
    chk(code == exp, req, code, exp);
    chk(update == (exp != m_code), {req, " R9 pulse"}, update, exp != m_code);
    @(posedge clk); #2;
    chk(update == 1'b0, {req, " R9 pulse width"}, update, 0);
    @(negedge clk); cs_n = 1'b1;
    m_code = exp;
  endtask

  task automatic t_reset();
    chk(code == 12'h000, "R1 code after reset", code, 0);
    chk(update == 1'b0, "R1 update after reset", update, 0);
    bus_op(2'd3, 4'h0, 1'b0, "R1 transfer of reset holding");
  endtask

  task automatic t_load_and_xfer();
    bus_op(2'd0, 4'h3, 1'b0, "R2 R4 low nibble");
    bus_op(2'd1, 4'hC, 1'b0, "R2 R4 middle nibble");
    bus_op(2'd2, 4'hA, 1'b0, "R2 R4 high nibble");
    bus_op(2'd3, 4'h0, 1'b0, "R3 transfer A C 3");
    chk(code == 12'hAC3, "R3 nibble order", code, 12'hAC3);
    bus_op(2'd1, 4'h5, 1'b0, "R4 middle only");
    bus_op(2'd3, 4'hF, 1'b0, "R3 transfer after middle");
    bus_op(2'd3, 4'h7, 1'b0, "R9 same value transfer no pulse");
  endtask

  task automatic t_deselected();
    bus_op(2'd0, 4'hE, 1'b1, "R5 write with cs high");
    bus_op(2'd3, 4'h0, 1'b1, "R5 transfer with cs high");
    bus_op(2'd3, 4'h0, 1'b0, "R5 holding untouched");
    chk(code == 12'hA53, "R5 code after real transfer", code, 12'hA53);
  endtask

  task automatic t_clear();
    @(posedge clk); #3 clr_n = 1'b0;
    #1 chk(code == 12'h000, "R7 async clear", code, 0);
    chk(update == 1'b1, "R9 pulse on clear", update, 1);
    @(posedge clk); #2;
    chk(update == 1'b0, "R9 clear pulse width", update, 0);
    repeat (2) @(posedge clk);
    #2 chk(code == 12'h000, "R7 clear held", code, 0);
    @(negedge clk); clr_n = 1'b1;
    m_code = 12'h000;
    bus_op(2'd3, 4'h0, 1'b0, "R8 holding survives clear");
    chk(code == 12'hA53, "R8 restored code", code, 12'hA53);
  endtask

  task automatic t_clear_vs_xfer();
    bus_op(2'd2, 4'h1, 1'b0, "R2 high nibble 1");
    @(negedge clk); addr = 2'd3; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    @(posedge clk); #3 clr_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 chk(code == 12'h000, "R7 clear overrides transfer", code, 0);
    @(negedge clk); cs_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk(code == 12'h000, "R6 no late commit", code, 0);
    @(negedge clk); clr_n = 1'b1;
    m_code = 12'h000;
    bus_op(2'd3, 4'h0, 1'b0, "R8 transfer after collision");
    chk(code == 12'h153, "R8 code 153", code, 12'h153);
  endtask

  task automatic t_long_strobe();
    bus_op(2'd0, 4'h9, 1'b0, "R2 low nibble 9");
    @(negedge clk); addr = 2'd3; cs_n = 1'b0; wr_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(code == 12'h153, "R6 no commit while strobe low", code, 12'h153);
    wr_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 chk(code == 12'h159, "R6 commit on rise", code, 12'h159);
    @(negedge clk); cs_n = 1'b1;
    m_code = 12'h159;
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_load_and_xfer();
    t_deselected();
    t_clear();
    t_clear_vs_xfer();
    t_long_strobe();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule